// File: doc/BRIEF.md
# Write-Ordering Issue Scoreboard

This block sits in the decode stage of an in-order pipeline whose path divides after register read into units with unequal latency. Here these are a fixed eight-cycle divider and a one-cycle ALU. A divide may be followed by a younger subtract that names the same destination register. If the subtract were allowed to go, it would reach writeback first, and the divide's late result would then overwrite the newer value. The scoreboard prevents this. It keeps, for each architectural register, a bit that marks a write still in flight and a record of which unit owns that write. It raises `stall` whenever the instruction in decode would write a register that is already marked. It also raises `stall` when an enabled source register is marked, which covers read-after-write hazards as well.

An instruction issues in a cycle when it is valid and not stalled. When it issues with its write enabled, its destination becomes marked and the unit it was sent to is recorded. Each functional unit reports its writebacks on its own port. A writeback clears a mark only when the port belongs to the unit that was recorded for that register. Register zero is hard-wired: it is never marked and never causes a stall. The stall decision is taken from the marks as they stand at the start of the cycle. A writeback therefore releases a stalled instruction one cycle later.

Top module: `waw_scoreboard`

## Requirements
- R1: After reset, no register is marked, and `stall` is low for any decoded instruction.
- R2: A valid, unstalled instruction with `dec_wr` high and a nonzero `dec_dst` marks that register from the next cycle onward.
- R3: `stall` is high when `dec_valid` and `dec_wr` are high and `dec_dst` names a marked register, which blocks a write-after-write reorder.
- R4: `stall` is high when a source whose enable is high names a marked register. A source whose enable is low has no effect on `stall`.
- R5: Register 0 is never marked, so writing it, reading it or naming it as a destination never produces a stall.
- R6: A writeback on the port of the unit recorded for a marked register (`dec_unit` 0 = ALU, 1 = divider) clears the mark, and `stall` drops in the following cycle.
- R7: A writeback on the other unit's port leaves the mark in place.
- R8: If an issue marks a register in the same cycle that a writeback to that register arrives, the new mark wins and the register stays marked.
- R9: A stalled instruction marks nothing.
- R10: While `dec_valid` is low, `stall` is low and nothing is marked.
- R11: With `dec_wr` low, the destination is neither compared nor marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_unit | input | 1 | Target unit: 0 = ALU, 1 = divider |
| dec_wr | input | 1 | Instruction writes its destination |
| dec_dst | input | AW (5) | Destination register |
| dec_src1_en | input | 1 | First source is read |
| dec_src1 | input | AW (5) | First source register |
| dec_src2_en | input | 1 | Second source is read |
| dec_src2 | input | AW (5) | Second source register |
| alu_wb_valid | input | 1 | ALU writeback this cycle |
| alu_wb_dst | input | AW (5) | ALU writeback register |
| div_wb_valid | input | 1 | Divider writeback this cycle |
| div_wb_dst | input | AW (5) | Divider writeback register |
| stall | output | 1 | Hold the decode stage |

## Verification
The hardest case to reach is a writeback that arrives for a register while a new issue marks that same register. In a well-formed pipeline this cannot happen, because the mark would already stall the issue. The stimulus therefore creates it on purpose. It first issues and retires an ALU write to a register, which leaves a stale ALU owner record behind. It then issues a fresh ALU write to that register and, in the same cycle, drives a stray ALU writeback to it. A probe instruction that reads the register afterwards must stall. The wrong-port writeback case is reached the same way, by driving a completion on the ALU port while the divider owns the register. Around these directed cases, a long randomized run uses a small register range to force frequent clashes. Its writebacks come from a behavioural model of a one-cycle ALU and an eight-cycle divider.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  typedef enum logic {
    UNIT_ALU = 1'b0,
    UNIT_DIV = 1'b1
  } unit_e;
endpackage

// File: rtl/wsb_hazard.sv
// Compares the decode instruction against the in-flight write marks.
module wsb_hazard
  import wsb_pkg::*;
#(
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic [NREG-1:0] pend,
  input  logic            dec_valid,
  input  logic            dec_wr,
  input  logic [AW-1:0]   dec_dst,
  input  logic            dec_src1_en,
  input  logic [AW-1:0]   dec_src1,
  input  logic            dec_src2_en,
  input  logic [AW-1:0]   dec_src2,
  output logic            stall,
  output logic            set_en
);
  logic dst_nz;
  logic waw_hit;
  logic raw1_hit;
  logic raw2_hit;

  always_comb begin
    dst_nz   = (dec_dst != '0);
    // Destination clash: an older write to the same register is still in flight.
    waw_hit  = dec_wr && pend[dec_dst];
    raw1_hit = dec_src1_en && pend[dec_src1];
    raw2_hit = dec_src2_en && pend[dec_src2];
    stall    = dec_valid && (waw_hit || raw1_hit || raw2_hit);
    set_en   = dec_valid && !stall && dec_wr && dst_nz;
  end
endmodule

// File: rtl/wsb_table.sv
// One in-flight mark and owner record per architectural register.
module wsb_table
  import wsb_pkg::*;
#(
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [AW-1:0]   set_idx,
  input  unit_e           set_unit,
  input  logic            alu_clr_en,
  input  logic [AW-1:0]   alu_clr_idx,
  input  logic            div_clr_en,
  input  logic [AW-1:0]   div_clr_idx,
  output logic [NREG-1:0] pend
);
  // Register 0 is hard-wired and has no storage.
  assign pend[0] = 1'b0;

  for (genvar r = 1; r < NREG; r++) begin : g_reg
    logic  pend_q;
    logic  pend_d;
    unit_e own_q;
    logic  hit_set;
    logic  hit_clr;

    always_comb begin
      hit_set = set_en && (set_idx == AW'(r));
      hit_clr = (alu_clr_en && (alu_clr_idx == AW'(r)) && (own_q == UNIT_ALU))
             || (div_clr_en && (div_clr_idx == AW'(r)) && (own_q == UNIT_DIV));
      // A new issue takes priority over a completion in the same cycle.
      if (hit_set)      pend_d = 1'b1;
      else if (hit_clr) pend_d = 1'b0;
      else              pend_d = pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
    end

    // The owner record is data: loaded only under its enable, with no reset.
    always_ff @(posedge clk) begin
      if (hit_set) own_q <= set_unit;
    end

    assign pend[r] = pend_q;
  end
endmodule

// File: rtl/waw_scoreboard.sv
module waw_scoreboard
  import wsb_pkg::*;
#(
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic          dec_unit,
  input  logic          dec_wr,
  input  logic [AW-1:0] dec_dst,
  input  logic          dec_src1_en,
  input  logic [AW-1:0] dec_src1,
  input  logic          dec_src2_en,
  input  logic [AW-1:0] dec_src2,
  input  logic          alu_wb_valid,
  input  logic [AW-1:0] alu_wb_dst,
  input  logic          div_wb_valid,
  input  logic [AW-1:0] div_wb_dst,
  output logic          stall
);
  logic [NREG-1:0] pend_vec;
  logic            set_en;
  unit_e           set_unit;

  assign set_unit = unit_e'(dec_unit);

  wsb_hazard #(.NREG(NREG), .AW(AW)) u_hazard (
    .pend        (pend_vec),
    .dec_valid   (dec_valid),
    .dec_wr      (dec_wr),
    .dec_dst     (dec_dst),
    .dec_src1_en (dec_src1_en),
    .dec_src1    (dec_src1),
    .dec_src2_en (dec_src2_en),
    .dec_src2    (dec_src2),
    .stall       (stall),
    .set_en      (set_en)
  );

  wsb_table #(.NREG(NREG), .AW(AW)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_en      (set_en),
    .set_idx     (dec_dst),
    .set_unit    (set_unit),
    .alu_clr_en  (alu_wb_valid),
    .alu_clr_idx (alu_wb_dst),
    .div_clr_en  (div_wb_valid),
    .div_clr_idx (div_wb_dst),
    .pend        (pend_vec)
  );
endmodule

// File: rtl/wsb_checker.sv
module wsb_checker #(
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic            dec_wr,
  input logic [AW-1:0]   dec_dst,
  input logic            dec_src1_en,
  input logic [AW-1:0]   dec_src1,
  input logic            alu_wb_valid,
  input logic            div_wb_valid,
  input logic            stall,
  input logic [NREG-1:0] pend_vec
);
  p_reg0_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_vec[0]);

  p_idle_nostall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !stall);

  p_waw_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_wr && pend_vec[dec_dst]) |-> stall);

  p_raw_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_src1_en && pend_vec[dec_src1]) |-> stall);

  p_issue_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !stall && dec_wr && dec_dst != '0) |=> pend_vec[$past(dec_dst)]);

  p_stall_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !alu_wb_valid && !div_wb_valid) |=> (pend_vec == $past(pend_vec)));
endmodule

bind waw_scoreboard wsb_checker #(.NREG(NREG), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_valid    (dec_valid),
  .dec_wr       (dec_wr),
  .dec_dst      (dec_dst),
  .dec_src1_en  (dec_src1_en),
  .dec_src1     (dec_src1),
  .alu_wb_valid (alu_wb_valid),
  .div_wb_valid (div_wb_valid),
  .stall        (stall),
  .pend_vec     (pend_vec)
);

// File: tb/waw_scoreboard_tb.sv
module waw_scoreboard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int AW = 5;
  localparam int DIV_LAT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 0, dec_unit = 0, dec_wr = 0, dec_src1_en = 0, dec_src2_en = 0;
  logic [AW-1:0] dec_dst = 0, dec_src1 = 0, dec_src2 = 0;
  logic alu_wb_valid = 0, div_wb_valid = 0;
  logic [AW-1:0] alu_wb_dst = 0, div_wb_dst = 0;
  logic stall;

  always #(CLK_PERIOD/2) clk = ~clk;

  waw_scoreboard #(.NREG(NREG), .AW(AW)) u_dut (.*);

  int n_tests = 0;
  int n_fail = 0;
  bit model_pend [NREG];
  bit model_own  [NREG];
  bit last_issue;
  bit last_unit;
  logic [AW-1:0] last_dst;

  // One cycle: drive at the falling edge, compare before the rising edge, update model at it.
  task automatic cyc(input bit v, input bit u, input bit w, input int d,
                     input bit e1, input int s1, input bit e2, input int s2,
                     input bit av, input int ad, input bit dv, input int dd,
                     input string tag);
    bit exp_stall;
    @(negedge clk);
    dec_valid = v; dec_unit = u; dec_wr = w; dec_dst = AW'(d);
    dec_src1_en = e1; dec_src1 = AW'(s1); dec_src2_en = e2; dec_src2 = AW'(s2);
    alu_wb_valid = av; alu_wb_dst = AW'(ad); div_wb_valid = dv; div_wb_dst = AW'(dd);
    #1;
    exp_stall = v && ((w && model_pend[d]) || (e1 && model_pend[s1]) || (e2 && model_pend[s2]));
    n_tests++;
    if (stall !== exp_stall) begin
      n_fail++;
      $display("FAIL %s: stall actual=%0b expected=%0b (dst=%0d s1=%0d s2=%0d)",
               tag, stall, exp_stall, d, s1, s2);
    end
    @(posedge clk);
    if (av && model_pend[ad] && model_own[ad] == 1'b0) model_pend[ad] = 0;
    if (dv && model_pend[dd] && model_own[dd] == 1'b1) model_pend[dd] = 0;
    last_issue = v && !exp_stall && w && d != 0;
    last_unit = u;
    last_dst = AW'(d);
    if (last_issue) begin
      model_pend[d] = 1;
      model_own[d] = u;
    end
  endtask

  // Probe: a valid read-only instruction on one source.
  task automatic probe(input int r, input string tag);
    cyc(1, 0, 0, 0, 1, r, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit dv_v [DIV_LAT];
    int dv_d [DIV_LAT];
    bit al_v;
    int al_d;
    for (int i = 0; i < NREG; i++) begin model_pend[i] = 0; model_own[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: clean state after reset
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
    for (int r = 0; r < 8; r++) probe(r, "R1 probe");

    // R2: divide writes r3; then R3: a younger ALU write to r3 stalls
    cyc(1, 1, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R2 issue div r3");
    cyc(1, 0, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R3 waw r3");
    // R9: stalled instruction (RAW on r3) to r7 marks nothing
    repeat (3) cyc(1, 0, 1, 7, 1, 3, 0, 0, 0, 0, 0, 0, "R9 stalled");
    cyc(1, 0, 1, 9, 0, 0, 1, 7, 0, 0, 0, 0, "R9 r7 not marked");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 9, 0, 0, "R6 alu clears r9");
    // R7: ALU writeback to divider-owned r3 leaves mark
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 3, 0, 0, "R7 wrong port");
    probe(3, "R7 still marked");
    // R4: disabled source ignored
    cyc(1, 0, 1, 4, 0, 3, 0, 3, 0, 0, 0, 0, "R4 disabled src");
    cyc(1, 0, 1, 5, 0, 0, 1, 4, 1, 4, 0, 0, "R4 src2 marked");
    // R6: divider writeback clears r3, stall drops next cycle
    cyc(1, 0, 0, 0, 1, 3, 0, 0, 0, 0, 1, 3, "R6 same-cycle still stalls");
    probe(3, "R6 cleared");
    // R5: register 0
    cyc(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 write r0");
    cyc(1, 0, 1, 0, 1, 0, 1, 0, 0, 0, 0, 0, "R5 r0 no stall");
    // R10: invalid instruction ignored
    cyc(0, 1, 1, 9, 1, 9, 1, 9, 0, 0, 0, 0, "R10 invalid");
    probe(9, "R10 r9 not marked");
    // R11: write disabled
    cyc(1, 1, 1, 10, 0, 0, 0, 0, 0, 0, 0, 0, "R11 mark r10");
    cyc(1, 0, 0, 10, 0, 0, 0, 0, 0, 0, 0, 0, "R11 dst not compared");
    cyc(1, 0, 0, 11, 0, 0, 0, 0, 0, 0, 1, 10, "R11 no mark r11");
    probe(11, "R11 r11 clear");
    // R8: stale ALU owner on r6, then issue and stray writeback collide
    cyc(1, 0, 1, 6, 0, 0, 0, 0, 0, 0, 0, 0, "R8 setup issue");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 6, 0, 0, "R8 setup clear");
    cyc(1, 0, 1, 6, 0, 0, 0, 0, 1, 6, 0, 0, "R8 collide");
    probe(6, "R8 set wins");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 6, 0, 0, "R8 drain");
    probe(6, "R8 drained");

    // Randomized traffic with 1-cycle ALU and fixed-latency divider completions
    for (int i = 0; i < DIV_LAT; i++) begin dv_v[i] = 0; dv_d[i] = 0; end
    al_v = 0; al_d = 0;
    for (int k = 0; k < 3000; k++) begin
      cyc(($urandom % 4) != 0, $urandom % 2, ($urandom % 5) != 0, $urandom % 8,
          $urandom % 2, $urandom % 8, $urandom % 2, $urandom % 8,
          al_v, al_d, dv_v[0], dv_d[0], "R3 R4 random");
      for (int i = 0; i < DIV_LAT - 1; i++) begin dv_v[i] = dv_v[i+1]; dv_d[i] = dv_d[i+1]; end
      dv_v[DIV_LAT-1] = last_issue && last_unit;
      dv_d[DIV_LAT-1] = int'(last_dst);
      al_v = last_issue && !last_unit;
      al_d = int'(last_dst);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule